// File: doc/BRIEF.md
# Multi-Source System Reset Controller

The block merges one external reset pin with seven internal reset causes into a single CPU/peripheral reset. The internal causes are power-on, two voltage-detection levels, watchdog, clock fault, trimming-data fault and flash standby. Power-on reset is the block's own asynchronous reset `rst_ni`. The other six causes arrive as active-high pulses on `cause_i`. Whenever any source is active, a warm-up counter is cleared. The system reset is released only after the counter has run a full, parameterised interval with every source quiet.

A small byte-wide register interface has three registers. The first holds a disable bit for the external pin. The second is a key register: the disable bit only takes effect while the key register has last been written with 0xB2. The third is a sticky, write-1-to-clear record of which internal cause fired. Only power-on reset clears the disable bit, the key state and the cause record. Resets from the pin or from the other causes leave them unchanged.

Top module: `reset_hub`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no` is low. After power-on, the control register reads 0x00, the key register reads 0x00 and the flag register reads 0x01 (bit 0 is the power-on flag).
- R2: Register addresses are 0 for control, 1 for key and 2 for flags. Control bit 0 is the external-pin disable bit, where 1 means disabled. Control bits 7..1 read as 0 whatever is written to them.
- R3: `sys_rst_no` stays low while any source is active. It rises exactly WARM_CYCLES clock edges after the last edge at which a source was sampled active. For power-on, that last edge is the release of `rst_ni`.
- R4: A pulse on any `cause_i` bit drives `sys_rst_no` low and `warm_rst_o` high at the next clock edge.
- R5: `cause_i[k]` sets flag bit k+1, in the order voltage 1, voltage 2, watchdog, clock fault, trimming, flash standby. Flags are sticky.
- R6: Writing 1 to a flag bit clears it. A cause arriving in the same cycle as the clear wins.
- R7: A low on `ext_rst_ni`, passed through a two-flop synchronizer, holds `sys_rst_no` low from the third edge onward, unless the pin is disabled.
- R8: The disable bit blocks the pin only while the key register is armed. Writing 0xB2 to the key register arms it (it reads 0x01). Writing any other value disarms it (it reads 0x00).
- R9: Pin resets and internal-cause resets leave the disable bit, the key state and the flags unchanged.
- R10: An external pin reset sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| cause_i | input | 6 | Internal reset cause pulses, active high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| sys_rst_no | output | 1 | CPU/peripheral reset, active low |
| warm_rst_o | output | 1 | Warm-up counter reset, high while a source was active on the previous edge |

## Verification
The assertions assume that `cause_i`, `wr_i`, `addr_i` and `wdata_i` are synchronous to `clk_i` and settle between edges. They also assume that `cause_i` is held at zero while `rst_ni` is low, so no flag can be traced to a pulse issued during power-on. The bench drives every input on the falling edge and keeps the causes quiet during power-on. It draws cause patterns and clear masks from a fixed seed and sets directed key and disable combinations against the pin.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam logic [DATA_W-1:0] KEY_CODE = 8'hB2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_KEY   = 2'd1,
    REG_FLAGS = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], pin_ni};
  end

  assign req_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/warmup_timer.sv
module warmup_timer #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  output logic hold_no,
  output logic warm_rst_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hold_nq, warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      hold_nq <= 1'b0;
      warm_q  <= 1'b1;
    end else begin
      warm_q <= src_i;
      if (src_i) begin
        cnt_q   <= '0;
        hold_nq <= 1'b0;
      end else if (cnt_q != DONE) begin
        cnt_q   <= cnt_q + 1'b1;
        hold_nq <= (cnt_q == LAST);
      end
    end
  end

  assign hold_no    = hold_nq;
  assign warm_rst_o = warm_q;
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int unsigned NUM_CAUSE = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_CAUSE-1:0] cause_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 dis_o,
  output logic                 armed_o,
  output logic [NUM_CAUSE:0]   flags_o
);
  localparam int unsigned FLAG_W = NUM_CAUSE + 1;
  localparam logic [FLAG_W-1:0] FLAG_RST = FLAG_W'(1);

  reg_addr_e         addr;
  logic              dis_q, armed_q;
  logic [FLAG_W-1:0] flags_q, clr;

  assign addr = reg_addr_e'(addr_i);
  assign clr  = (wr_i && addr == REG_FLAGS) ? wdata_i[FLAG_W-1:0] : '0;

  // only power-on (rst_ni) clears this state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q   <= 1'b0;
      armed_q <= 1'b0;
      flags_q <= FLAG_RST;
    end else begin
      if (wr_i && addr == REG_CTRL) dis_q   <= wdata_i[0];
      if (wr_i && addr == REG_KEY)  armed_q <= (wdata_i == KEY_CODE);
      flags_q <= (flags_q & ~clr) | {cause_i, 1'b0};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      REG_CTRL:  rdata_o[0] = dis_q;
      REG_KEY:   rdata_o[0] = armed_q;
      REG_FLAGS: rdata_o[FLAG_W-1:0] = flags_q;
      default:   rdata_o = '0;
    endcase
  end

  assign dis_o   = dis_q;
  assign armed_o = armed_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import rstc_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_CAUSE   = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_rst_ni,
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 sys_rst_no,
  output logic                 warm_rst_o
);
  logic             pin_req, ext_req, src_any;
  logic             dis_w, armed_w;
  logic [NUM_CAUSE:0] flags_w;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_ni(ext_rst_ni), .req_o(pin_req)
  );

  rstc_regs #(.NUM_CAUSE(NUM_CAUSE)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .cause_i,
    .rdata_o, .dis_o(dis_w), .armed_o(armed_w), .flags_o(flags_w)
  );

  assign ext_req = pin_req & ~(dis_w & armed_w);
  assign src_any = ext_req | (|cause_i);

  warmup_timer #(.CYCLES(WARM_CYCLES)) u_warm (
    .clk_i, .rst_ni, .src_i(src_any), .hold_no(sys_rst_no), .warm_rst_o
  );
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk
  import rstc_pkg::*;
#(
  parameter int unsigned NUM_CAUSE = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CAUSE-1:0] cause_i,
  input logic                 wr_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic                 sys_rst_no,
  input logic                 warm_rst_o,
  input logic                 dis_w,
  input logic                 armed_w,
  input logic [NUM_CAUSE:0]   flags_w
);
  a_r4_cause_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_i) |=> (!sys_rst_no && warm_rst_o));

  a_r3_hold_while_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> !sys_rst_no);

  a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_i) |=> ((flags_w & $past({cause_i, 1'b0})) == $past({cause_i, 1'b0})));

  a_r10_no_spont_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_w & ~$past(flags_w) & ~$past({cause_i, 1'b0})) == '0));

  a_r9_dis_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == REG_CTRL) |=> $stable(dis_w));

  a_r8_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_KEY && wdata_i != KEY_CODE) |=> !armed_w);
endmodule

bind reset_hub reset_hub_chk #(.NUM_CAUSE(NUM_CAUSE)) u_chk (
  .clk_i, .rst_ni, .cause_i, .wr_i, .addr_i, .wdata_i,
  .sys_rst_no, .warm_rst_o, .dis_w, .armed_w, .flags_w
);

// File: tb/sim_reset_hub.sv
`timescale 1ns/1ps
module sim_reset_hub;
  localparam int WARM = 16;
  logic       clk_i = 1'b0, rst_ni = 1'b0, ext_rst_ni = 1'b1, wr_i = 1'b0;
  logic [5:0] cause_i = '0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       sys_rst_no, warm_rst_o;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_flags;

  always #2 clk_i = ~clk_i;

  reset_hub #(.WARM_CYCLES(WARM)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    cyc(1);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a; #0.5; d = rdata_o;
  endtask

  function automatic logic [7:0] flag_bits(logic [5:0] c);
    return {1'b0, c, 1'b0};
  endfunction

  task automatic measure_release(output int n);
    n = 0;
    while (!sys_rst_no && n < 4 * WARM + 20) begin cyc(1); n++; end
  endtask

  task automatic run();
    logic [7:0] d;
    int n;
    // R1 reset state
    @(negedge clk_i);
    chk("R1 sys_rst_no in POR", sys_rst_no, 0);
    rst_ni = 1'b1;
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 key", d, 8'h00);
    rd(2'd2, d); chk("R1 flags", d, 8'h01);
    exp_flags = 8'h01;
    cyc(WARM - 1);
    chk("R3 still held at WARM-1", sys_rst_no, 0);
    cyc(1);
    chk("R3 release after POR", sys_rst_no, 1);
    // R2 control bits
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 ctrl reads 0x01", d, 8'h01);
    // R4/R3/R5/R9 random cause patterns
    void'($urandom(32'd1234));
    for (int i = 0; i < 24; i++) begin
      logic [5:0] c; int len;
      c = 6'($urandom());
      if (c == 0) c = 6'h1;
      len = 1 + int'($urandom() % 3);
      cause_i = c;
      cyc(1);
      chk("R4 sys_rst_no low after cause", sys_rst_no, 0);
      chk("R4 warm_rst_o high after cause", warm_rst_o, 1);
      cyc(len - 1);
      cause_i = '0;
      exp_flags |= flag_bits(c);
      measure_release(n);
      chk("R3 warm-up length", n, WARM);
      rd(2'd2, d); chk("R5 flags sticky", d, exp_flags);
      rd(2'd0, d); chk("R9 disable kept", d, 8'h01);
      if ($urandom() % 2) begin
        logic [7:0] m;
        m = 8'($urandom()) & 8'h7F;
        wr(2'd2, m);
        exp_flags &= ~m;
        rd(2'd2, d); chk("R6 w1c", d, exp_flags);
      end
    end
    wr(2'd2, 8'h7F); exp_flags = 0;
    rd(2'd2, d); chk("R6 clear all", d, 8'h00);
    // R6 set wins over clear
    cause_i = 6'h01; addr_i = 2'd2; wdata_i = 8'h02; wr_i = 1'b1;
    cyc(1);
    wr_i = 1'b0; cause_i = '0;
    rd(2'd2, d); chk("R6 set wins", d, 8'h02);
    measure_release(n);
    wr(2'd2, 8'h7F);
    // R7 pin active: disabled but not armed
    ext_rst_ni = 1'b0;
    cyc(2);
    chk("R7 not yet at 2 edges", sys_rst_no, 1);
    cyc(1);
    chk("R7 pin reset", sys_rst_no, 0);
    cyc(5);
    ext_rst_ni = 1'b1;
    measure_release(n);
    chk("R7 release after pin", sys_rst_no, 1);
    rd(2'd2, d); chk("R10 no flag from pin", d, 8'h00);
    rd(2'd0, d); chk("R9 disable kept over pin", d, 8'h01);
    // R8 arm then pin is blocked
    wr(2'd1, 8'hB2);
    rd(2'd1, d); chk("R8 armed", d, 8'h01);
    ext_rst_ni = 1'b0;
    cyc(10);
    chk("R8 pin blocked", sys_rst_no, 1);
    wr(2'd1, 8'h55);
    rd(2'd1, d); chk("R8 disarmed", d, 8'h00);
    cyc(3);
    chk("R8 pin active after disarm", sys_rst_no, 0);
    ext_rst_ni = 1'b1;
    measure_release(n);
    // R8 armed but disable bit 0
    wr(2'd1, 8'hB2);
    wr(2'd0, 8'h00);
    ext_rst_ni = 1'b0;
    cyc(3);
    chk("R8 enabled pin resets", sys_rst_no, 0);
    ext_rst_ni = 1'b1;
    measure_release(n);
    rd(2'd1, d); chk("R9 key kept over pin", d, 8'h01);
    // R1 power-on again clears state
    wr(2'd0, 8'h01);
    cause_i = 6'h20; cyc(1); cause_i = '0;
    rst_ni = 1'b0; #0.5;
    chk("R1 async assert", sys_rst_no, 0);
    cyc(2);
    rst_ni = 1'b1;
    rd(2'd0, d); chk("R1 ctrl cleared", d, 8'h00);
    rd(2'd1, d); chk("R1 key cleared", d, 8'h00);
    rd(2'd2, d); chk("R1 flags only POR", d, 8'h01);
    measure_release(n);
    chk("R3 release after second POR", n, WARM);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule